// File: doc/BRIEF.md
# SPI Pixel Write Command Receiver

This block takes pixel-write commands from an external microcontroller acting as SPI master and turns them into one write request for a video memory controller. The three serial inputs (active-low select, serial clock and data) are brought into the system pixel-clock domain through two-flop synchronizers. Edges are then detected on that clock, so the block has no second clock domain of its own.

While select is low, the block shifts in a 24-bit word. Bits are sampled on serial-clock rising edges, most significant bit first. When select returns high after exactly 24 bits, the word is split into a color byte, an X byte and a Y byte. These fields are latched onto the outputs and a request flag is raised. The flag and the fields hold until the memory side returns an acknowledge. Only after that does the block go idle and accept the next command. A frame of any other length is dropped. Select or clock activity that arrives while a write is still waiting is ignored.

Top module: `pix_cmd_rx`

## Requirements
- R1: After reset, wr_req_o is low and color_o, x_o and y_o are all zero.
- R2: A command starts on a falling edge of cs_ni. While cs_ni is low, mosi_i is sampled on each rising edge of sclk_i, most significant bit first. Serial clock edges seen while cs_ni is high shift nothing.
- R3: Of the 24 bits shifted in, the first eight form color_o, the next eight form x_o and the last eight form y_o. Bit 23 of the word is the first bit sent.
- R4: When cs_ni rises after exactly 24 sampled bits, wr_req_o goes high within four clock cycles. The three fields are valid from the same cycle.
- R5: When cs_ni rises after any bit count other than 24 (none, fewer or more), no request is raised and the outputs keep their previous values.
- R6: While wr_req_o is high, wr_req_o, color_o, x_o and y_o stay constant until an acknowledge is sampled.
- R7: wr_req_o falls in the cycle after wr_ack_i is sampled high while it is set. The next complete frame then raises a new request.
- R8: Select and serial clock activity during a pending request is ignored. It does not change the fields and does not cause a further request after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| mosi_i | input | 1 | Serial data from the master, asynchronous |
| wr_ack_i | input | 1 | Write serviced acknowledge from the memory controller |
| wr_req_o | output | 1 | Pending write request |
| color_o | output | 8 | Color byte of the pending write |
| x_o | output | 8 | X coordinate of the pending write |
| y_o | output | 8 | Y coordinate of the pending write |

## Verification
The hardest situation to reach is a full command arriving while an earlier write is still unacknowledged. A correct block must drop this command completely, yet a careless one could latch it silently or replay it after the acknowledge. The bench holds the acknowledge off on purpose and shifts a second 24-bit frame with different data. It checks that the fields and the flag are unchanged. It then acknowledges and checks that the flag stays low. Frames of 0, 23 and 25 bits are run from the vector table to cover the length-mismatch cases on both sides of 24.

// File: rtl/pix_cmd_pkg.sv
package pix_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_WAIT = 2'd2
  } rx_state_e;
endpackage

// File: rtl/pix_cmd_sync.sv
module pix_cmd_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pix_cmd_shift.sv
module pix_cmd_shift #(
  parameter int CMD_W = 24,
  localparam int CNT_W = $clog2(CMD_W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [CMD_W-1:0] word_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CMD_W + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
    end else if (shift_i) begin
      word_o <= {word_o[CMD_W-2:0], bit_i};
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1; // saturate past full
    end
  end

  assign full_o = (cnt_q == CNT_FULL);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OVER);
  // R2
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pix_cmd_rx.sv
module pix_cmd_rx
  import pix_cmd_pkg::*;
#(
  parameter int COLOR_W   = 8,
  parameter int X_W       = 8,
  parameter int Y_W       = 8,
  parameter int SYNC_DEPTH = 2,
  localparam int CMD_W    = COLOR_W + X_W + Y_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               mosi_i,
  input  logic               wr_ack_i,
  output logic               wr_req_o,
  output logic [COLOR_W-1:0] color_o,
  output logic [X_W-1:0]     x_o,
  output logic [Y_W-1:0]     y_o
);
  logic [2:0] pins_s;
  logic cs_s, sclk_s, mosi_s;
  logic cs_q, sclk_q;
  logic cs_fall, cs_rise, sclk_rise;
  logic [CMD_W-1:0] word;
  logic word_full;
  rx_state_e state_q, state_d;
  logic commit;

  pix_cmd_sync #(.W(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mosi_i, sclk_i, cs_ni}),
    .q_o   (pins_s)
  );
  assign {mosi_s, sclk_s, cs_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  assign cs_fall   = cs_q & ~cs_s;
  assign cs_rise   = ~cs_q & cs_s;
  assign sclk_rise = ~sclk_q & sclk_s;

  pix_cmd_shift #(.CMD_W(CMD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE && cs_fall),
    .shift_i(state_q == ST_RECV && sclk_rise && !cs_s),
    .bit_i  (mosi_s),
    .word_o (word),
    .full_o (word_full)
  );

  assign commit = (state_q == ST_RECV) && cs_rise && word_full;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cs_fall) state_d = ST_RECV;
      ST_RECV: if (cs_rise) state_d = word_full ? ST_WAIT : ST_IDLE;
      ST_WAIT: if (wr_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      color_o <= '0;
      x_o     <= '0;
      y_o     <= '0;
    end else begin
      state_q <= state_d;
      if (commit) {color_o, x_o, y_o} <= word;
    end
  end

  assign wr_req_o = (state_q == ST_WAIT);

  // R4
  req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_req_o) |-> $past(word_full) && $past(cs_rise));
  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o);
  // R6
  field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> $stable(color_o) && $stable(x_o) && $stable(y_o));
  // R7
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_ack_i |=> !wr_req_o);
  // R5
  short_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECV) && cs_rise && !word_full |=> !wr_req_o);
endmodule

// File: tb/pix_cmd_rx_tb.sv
module pix_cmd_rx_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, mosi = 1'b0, ack = 1'b0;
  logic wr_req;
  logic [7:0] color, x, y;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pix_cmd_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .mosi_i(mosi),
    .wr_ack_i(ack), .wr_req_o(wr_req), .color_o(color), .x_o(x), .y_o(y)
  );

  localparam int NV = 6;
  localparam int          VEC_BITS [NV] = '{24, 24, 23, 25, 0, 24};
  localparam logic [31:0] VEC_DATA [NV] = '{32'h00A53C7E, 32'h0000FF01, 32'h00123456,
                                            32'h01ABCDEF, 32'h00000000, 32'h00FF0080};
  localparam bit          VEC_REQ  [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [31:0] d);
    cs_ni = 1'b0;
    tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = d[i];
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    cs_ni = 1'b1;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  logic [23:0] last;

  initial begin
    tick(3);
    // R1 reset state
    chk(wr_req == 1'b0, "R1 req", {31'b0, wr_req}, 0);
    chk({color, x, y} == 24'h0, "R1 fields", {8'h0, color, x, y}, 0);
    rst_ni = 1'b1;
    tick(2);
    // R2: serial clock toggling with select high must shift nothing
    for (int k = 0; k < 5; k++) begin mosi = 1'b1; sclk = 1'b1; tick(4); sclk = 1'b0; tick(4); end
    chk(wr_req == 1'b0, "R2 idle sclk", {31'b0, wr_req}, 0);

    last = 24'h0;
    for (int v = 0; v < NV; v++) begin
      send(VEC_BITS[v], VEC_DATA[v]);
      tick(5);
      chk(wr_req == VEC_REQ[v], VEC_REQ[v] ? "R4 req" : "R5 no req", {31'b0, wr_req}, {31'b0, VEC_REQ[v]});
      if (VEC_REQ[v]) last = VEC_DATA[v][23:0];
      // R3 field split, R5 outputs unchanged on discard
      chk(color == last[23:16], "R3 color", {24'h0, color}, {24'h0, last[23:16]});
      chk(x == last[15:8], "R3 x", {24'h0, x}, {24'h0, last[15:8]});
      chk(y == last[7:0], "R3 y", {24'h0, y}, {24'h0, last[7:0]});
      if (wr_req) begin
        tick(6);
        chk(wr_req == 1'b1, "R6 hold", {31'b0, wr_req}, 1);
        do_ack();
        chk(wr_req == 1'b0, "R7 drop", {31'b0, wr_req}, 0);
      end
      tick(3);
    end

    // R8: full frame during pending request is ignored
    send(24, 32'h00112233);
    tick(5);
    chk(wr_req == 1'b1, "R4 pre R8", {31'b0, wr_req}, 1);
    send(24, 32'h00DDEEFF);
    tick(5);
    chk({color, x, y} == 24'h112233, "R8 fields", {8'h0, color, x, y}, 32'h112233);
    chk(wr_req == 1'b1, "R6 still pending", {31'b0, wr_req}, 1);
    do_ack();
    tick(10);
    chk(wr_req == 1'b0, "R8 no replay", {31'b0, wr_req}, 0);
    // R7: new command accepted after acknowledge
    send(24, 32'h00445566);
    tick(5);
    chk(wr_req == 1'b1 && {color, x, y} == 24'h445566, "R7 next cmd", {7'b0, wr_req, color, x, y}, 32'h01445566);
    do_ack();
    tick(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule